// File: doc/BRIEF.md
# Slot-Register Round-Robin Arbiter with Grant Queue

This block shares one memory-side target among several initiator ports. Each initiator sends one request record. The record carries the initiator id, the target id, a request tag and an address. A record counts only if its target id equals the id given to this arbiter instance. The record is then parked in a holding slot chosen by its initiator id. A rotating selector picks one parked request per clock. It empties that slot, reports the choice on a selection output and appends the record to an internal queue.

Granting is a separate step. While the target reports that it is free, the oldest queued record is handed out on the grant output, one per clock. An observer can therefore see two events for every request: when it won the round-robin contest, and when it was actually granted. Every initiator belongs to a single round-robin group. Each initiator keeps at most one request in flight and waits until that request has been served.

Top module: `slot_rr_arbiter`

## Requirements
- R1: A request record has four fields: initiator id, target id, request tag and address. The selection and grant outputs carry the initiator id, tag and address exactly as they arrived.
- R2: Initiator id m always fills holding slot m (ids 0 to N-1). The request on input port p uses bits [p*W +: W] of each flat request bus.
- R3: A request whose target id differs from the THIS_SID parameter fills no slot, and no selection or grant ever follows from it.
- R4: After each selection, the next winner is the lowest occupied slot above the previous winner. If no higher slot is occupied, the winner wraps to the lowest occupied slot.
- R5: Reset places the previous-winner pointer on the top slot, so slot 0 has first priority. A reset also discards any winner history built up before it.
- R6: A request presented at clock edge e is parked at e. It can be selected at e+1, with sel_valid high for exactly one cycle after that edge. Selection empties the slot and appends the record to the queue.
- R7: A grant is issued only at an edge where slv_free is high and the queue is non-empty. Grants leave the queue in the order the selections were made. While slv_free is low, gnt_valid stays low.
- R8: At most one selection and at most one grant happen per clock, and both may happen in the same clock. The queue holds N entries and never overflows.
- R9: While reset is held, and in the cycle after it, sel_valid and gnt_valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N | One request strobe per initiator port |
| req_mid | input | N*MID_W | Initiator id per port |
| req_sid | input | N*SID_W | Target id per port |
| req_rid | input | N*RID_W | Request tag per port |
| req_addr | input | N*ADDR_W | Address per port |
| slv_free | input | 1 | Target can accept a grant this clock |
| sel_valid | output | 1 | A round-robin winner was chosen |
| sel_mid | output | MID_W | Winner initiator id |
| sel_rid | output | RID_W | Winner request tag |
| sel_addr | output | ADDR_W | Winner address |
| gnt_valid | output | 1 | The head of the queue was granted |
| gnt_mid | output | MID_W | Granted initiator id |
| gnt_rid | output | RID_W | Granted request tag |
| gnt_addr | output | ADDR_W | Granted address |

## Verification
The bench targets rotation that starts from different winner positions and sparse patterns that must wrap around. A selector that restarts from slot 0 every round, or that skips the wrap, would produce a different winner order. Requests for another target are mixed in with valid ones; a missing target filter would make an extra selection appear. The bench also holds the target busy and then frees it for a single clock to expose grants issued while the target is busy, and grants issued out of queue order. It resets mid-run to confirm that slot 0 regains first priority. Overlapping selection and grant in the same clock checks that neither event is lost.

// File: rtl/arb_pkg.sv
// Shared widths and the request record for the slot arbiter.
package arb_pkg;
    localparam int unsigned ARB_MASTERS = 4;
    localparam int unsigned ARB_MID_W   = (ARB_MASTERS > 1) ? $clog2(ARB_MASTERS) : 1;
    localparam int unsigned ARB_SID_W   = 4;
    localparam int unsigned ARB_RID_W   = 8;
    localparam int unsigned ARB_ADDR_W  = 16;

    typedef struct packed {
        logic [ARB_MID_W-1:0]  mid;
        logic [ARB_RID_W-1:0]  rid;
        logic [ARB_ADDR_W-1:0] addr;
    } arb_req_t;
endpackage

// File: rtl/arb_slot_bank.sv
// Holding slots, one per initiator and indexed by initiator id.
// Keeps only the requests addressed to MY_SID.
// Assumes an initiator never re-issues while its slot is still occupied.
module arb_slot_bank
    import arb_pkg::*;
#(
    parameter int unsigned N     = ARB_MASTERS,
    parameter int unsigned SID_W = ARB_SID_W,
    parameter logic [SID_W-1:0] MY_SID = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         in_valid,
    input  logic [N*SID_W-1:0]   in_sid,
    input  arb_req_t             in_rec [N],
    input  logic                 take,
    input  logic [ARB_MID_W-1:0] take_idx,
    output logic [N-1:0]         occ,
    output arb_req_t             slot [N]
);
    // Occupancy: clear the taken slot, then set the slots of matching arrivals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            if (take) occ[take_idx] <= 1'b0;
            for (int p = 0; p < N; p++) begin
                if (in_valid[p] && in_sid[p*SID_W +: SID_W] == MY_SID)
                    occ[in_rec[p].mid] <= 1'b1;
            end
        end
    end

    // Payload: capture the record of each matching arrival.
    always_ff @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            if (in_valid[p] && in_sid[p*SID_W +: SID_W] == MY_SID)
                slot[in_rec[p].mid] <= in_rec[p];
        end
    end

    AST_SLOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !occ[$past(take_idx)]); // R6
endmodule

// File: rtl/arb_rr_picker.sv
// Round-robin selector over the occupancy vector.
// Searches upward from one above the previous winner and wraps to the lowest
// occupied slot. The pointer resets to the top slot so slot 0 goes first.
module arb_rr_picker
    import arb_pkg::*;
#(
    parameter int unsigned N = ARB_MASTERS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         occ,
    output logic                 win_valid,
    output logic [ARB_MID_W-1:0] win_idx
);
    logic [ARB_MID_W-1:0] last_q;
    logic                 hi_found;
    logic [ARB_MID_W-1:0] hi_idx;
    logic [ARB_MID_W-1:0] lo_idx;

    // Search: lowest occupied slot above the pointer, plus the lowest overall.
    always_comb begin
        hi_found = 1'b0;
        hi_idx   = '0;
        lo_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (occ[i]) begin
                lo_idx = ARB_MID_W'(i);
                if (ARB_MID_W'(i) > last_q) begin
                    hi_found = 1'b1;
                    hi_idx   = ARB_MID_W'(i);
                end
            end
        end
        win_valid = |occ;
        win_idx   = hi_found ? hi_idx : lo_idx;
    end

    // Pointer: remember the latest winner.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= ARB_MID_W'(N - 1);
        else if (win_valid) last_q <= win_idx;
    end

    AST_WIN_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> !occ[$past(win_idx)] || $past(occ[win_idx] == 1'b0)); // R4
endmodule

// File: rtl/arb_grant_fifo.sv
// In-order queue of selected requests, DEPTH entries deep.
// Assumes the producer never pushes while the queue is full.
module arb_grant_fifo
    import arb_pkg::*;
#(
    parameter int unsigned DEPTH = ARB_MASTERS
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  arb_req_t push_rec,
    input  logic     pop,
    output arb_req_t head,
    output logic     empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    arb_req_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    // Pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_rec;
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> count < CNT_W'(DEPTH)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0); // R7
endmodule

// File: rtl/slot_rr_arbiter.sv
// Shares one target among the initiator ports. Requests park in per-initiator
// slots, a round-robin selector moves one per clock into an in-order queue,
// and the queue head is granted whenever the target reports it is free.
// Assumes each initiator has at most one request outstanding.
module slot_rr_arbiter
    import arb_pkg::*;
#(
    parameter logic [ARB_SID_W-1:0] THIS_SID = 4'd5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ARB_MASTERS-1:0]          req_valid,
    input  logic [ARB_MASTERS*ARB_MID_W-1:0]  req_mid,
    input  logic [ARB_MASTERS*ARB_SID_W-1:0]  req_sid,
    input  logic [ARB_MASTERS*ARB_RID_W-1:0]  req_rid,
    input  logic [ARB_MASTERS*ARB_ADDR_W-1:0] req_addr,
    input  logic                            slv_free,
    output logic                            sel_valid,
    output logic [ARB_MID_W-1:0]            sel_mid,
    output logic [ARB_RID_W-1:0]            sel_rid,
    output logic [ARB_ADDR_W-1:0]           sel_addr,
    output logic                            gnt_valid,
    output logic [ARB_MID_W-1:0]            gnt_mid,
    output logic [ARB_RID_W-1:0]            gnt_rid,
    output logic [ARB_ADDR_W-1:0]           gnt_addr
);
    localparam int unsigned N = ARB_MASTERS;

    arb_req_t             in_rec [N];
    arb_req_t             slot   [N];
    logic [N-1:0]         occ;
    logic                 win_valid;
    logic [ARB_MID_W-1:0] win_idx;
    arb_req_t             win_rec;
    arb_req_t             head;
    logic                 empty;
    logic                 pop;

    // Unpack the flat per-port buses into records.
    for (genvar p = 0; p < N; p++) begin : g_port
        assign in_rec[p].mid  = req_mid [p*ARB_MID_W  +: ARB_MID_W];
        assign in_rec[p].rid  = req_rid [p*ARB_RID_W  +: ARB_RID_W];
        assign in_rec[p].addr = req_addr[p*ARB_ADDR_W +: ARB_ADDR_W];
    end

    arb_slot_bank #(.N(N), .SID_W(ARB_SID_W), .MY_SID(THIS_SID)) u_slots (
        .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_sid(req_sid),
        .in_rec(in_rec), .take(win_valid), .take_idx(win_idx),
        .occ(occ), .slot(slot)
    );

    arb_rr_picker #(.N(N)) u_pick (
        .clk(clk), .rst_n(rst_n), .occ(occ),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    assign win_rec = slot[win_idx];
    assign pop     = slv_free && !empty;

    arb_grant_fifo #(.DEPTH(N)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(win_valid), .push_rec(win_rec),
        .pop(pop), .head(head), .empty(empty)
    );

    // Event outputs: register the selection and the grant of this clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            sel_mid   <= '0;
            sel_rid   <= '0;
            sel_addr  <= '0;
            gnt_valid <= 1'b0;
            gnt_mid   <= '0;
            gnt_rid   <= '0;
            gnt_addr  <= '0;
        end else begin
            sel_valid <= win_valid;
            if (win_valid) begin
                sel_mid  <= win_rec.mid;
                sel_rid  <= win_rec.rid;
                sel_addr <= win_rec.addr;
            end
            gnt_valid <= pop;
            if (pop) begin
                gnt_mid  <= head.mid;
                gnt_rid  <= head.rid;
                gnt_addr <= head.addr;
            end
        end
    end

    AST_GNT_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> $past(slv_free)); // R7
endmodule

// File: tb/slot_rr_arbiter_bench.sv
module slot_rr_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] MY_SID = 4'd5;

    typedef struct packed {
        logic [3:0] mask;
        logic [3:0] foreign;
        logic [2:0] n;
        logic [7:0] order;
    } vec_t;

    // order: k-th expected winner in bits [2k+1:2k]
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'b1111, 4'b0000, 3'd4, 8'hE4},   // 0,1,2,3 from reset (R5, R4)
        '{4'b0101, 4'b0000, 3'd2, 8'h08},   // wrap: 0,2 (R4)
        '{4'b1011, 4'b0000, 3'd3, 8'h13},   // 3,0,1 (R4)
        '{4'b0110, 4'b0010, 3'd1, 8'h02},   // port 1 foreign: only 2 (R3)
        '{4'b0100, 4'b0000, 3'd1, 8'h02},   // lone same slot wraps to itself (R4)
        '{4'b1111, 4'b1111, 3'd0, 8'h00},   // all foreign (R3)
        '{4'b1111, 4'b0000, 3'd4, 8'h93},   // 3,0,1,2 (R4)
        '{4'b1001, 4'b0000, 3'd2, 8'h03}    // 3,0 (R4)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_valid = '0;
    logic [7:0]  req_mid = '0;
    logic [15:0] req_sid = '0;
    logic [31:0] req_rid = '0;
    logic [63:0] req_addr = '0;
    logic        slv_free = 1'b0;
    logic        sel_valid, gnt_valid;
    logic [1:0]  sel_mid, gnt_mid;
    logic [7:0]  sel_rid, gnt_rid;
    logic [15:0] sel_addr, gnt_addr;

    int checks = 0;
    int fails  = 0;

    slot_rr_arbiter #(.THIS_SID(MY_SID)) u_slot_rr_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mid(req_mid),
        .req_sid(req_sid), .req_rid(req_rid), .req_addr(req_addr),
        .slv_free(slv_free),
        .sel_valid(sel_valid), .sel_mid(sel_mid), .sel_rid(sel_rid), .sel_addr(sel_addr),
        .gnt_valid(gnt_valid), .gnt_mid(gnt_mid), .gnt_rid(gnt_rid), .gnt_addr(gnt_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rid(input logic [3:0] tag, input int m);
        return {tag, 4'(m)};
    endfunction

    function automatic logic [15:0] exp_addr(input logic [3:0] tag, input int m);
        return 16'h4000 + 16'(tag) * 16'h0100 + 16'(m) * 16'd4;
    endfunction

    // One-cycle request burst; port i carries initiator id i (R2).
    task automatic drive(input logic [3:0] mask, input logic [3:0] foreign, input logic [3:0] tag);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            req_valid[i]         = mask[i];
            req_mid[i*2 +: 2]    = 2'(i);
            req_sid[i*4 +: 4]    = foreign[i] ? MY_SID + 4'd1 : MY_SID;
            req_rid[i*8 +: 8]    = exp_rid(tag, i);
            req_addr[i*16 +: 16] = exp_addr(tag, i);
        end
        @(negedge clk);
        req_valid = '0;
    endtask

    // Observe events for a number of cycles and compare against the expected order.
    task automatic watch(input int n_sel, input logic [7:0] order, input logic [3:0] tag,
                         input int n_gnt, input int gnt_off, input int cycles);
        int ns = 0;
        int ng = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (sel_valid) begin
                if (ns < n_sel) begin
                    int m = int'(order[2*ns +: 2]);
                    check(sel_mid == 2'(m), "R4 selection order", sel_mid, m);
                    check(sel_rid == exp_rid(tag, m) && sel_addr == exp_addr(tag, m),
                          "R1 selected record", sel_rid, exp_rid(tag, m));
                end
                ns++;
            end
            if (gnt_valid) begin
                if (ng < n_gnt) begin
                    int m = int'(order[2*(ng + gnt_off) +: 2]);
                    check(gnt_mid == 2'(m), "R7 grant order", gnt_mid, m);
                    check(gnt_rid == exp_rid(tag, m) && gnt_addr == exp_addr(tag, m),
                          "R1 granted record", gnt_rid, exp_rid(tag, m));
                end
                ng++;
            end
        end
        check(ns == n_sel, "R6/R3 selection count", ns, n_sel);
        check(ng == n_gnt, "R7/R8 grant count", ng, n_gnt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!sel_valid && !gnt_valid, "R9 outputs in reset", {sel_valid, gnt_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sel_valid && !gnt_valid, "R9 outputs after reset", {sel_valid, gnt_valid}, 0);

        // Vector table: select with the target busy, then drain.
        for (int v = 0; v < NV; v++) begin
            slv_free = 1'b0;
            drive(VECS[v].mask, VECS[v].foreign, 4'(v));
            watch(int'(VECS[v].n), VECS[v].order, 4'(v), 0, 0, 6);
            slv_free = 1'b1;
            watch(0, VECS[v].order, 4'(v), int'(VECS[v].n), 0, 6);
            slv_free = 1'b0;
        end

        // R5: a mid-run reset restores slot 0 priority (pointer was at slot 0).
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!sel_valid && !gnt_valid, "R9 outputs in mid-run reset", {sel_valid, gnt_valid}, 0);
        rst_n = 1'b1;
        drive(4'b0011, 4'b0000, 4'hA);
        watch(2, 8'h04, 4'hA, 0, 0, 6);
        slv_free = 1'b1;
        watch(0, 8'h04, 4'hA, 2, 0, 6);
        slv_free = 1'b0;

        // R7: a one-clock free window yields exactly one grant, in order.
        slv_free = 1'b0;
        drive(4'b1111, 4'b0000, 4'hB);
        watch(4, 8'h4E, 4'hB, 0, 0, 6);
        slv_free = 1'b1;
        watch(0, 8'h4E, 4'hB, 1, 0, 1);
        slv_free = 1'b0;
        watch(0, 8'h4E, 4'hB, 0, 0, 4);
        slv_free = 1'b1;
        watch(0, 8'h4E, 4'hB, 3, 1, 6);

        // R8: selection and grant overlapping in the same clocks.
        drive(4'b0011, 4'b0000, 4'hC);
        watch(2, 8'h04, 4'hC, 2, 0, 8);
        slv_free = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule